// File: doc/BRIEF.md
# Serial Camera-Control Bus Master

This block drives the two wires of a serial camera-control bus towards one slave device. A host asks for one transfer at a time: a read/write flag, an 8-bit register sub-address and, for writes, an 8-bit value. The block produces the clock line and the data line, returns the read byte and pulses a done flag once the transfer and its trailing guard time are both over.

The data line is open-drain. The block has a pull-low enable output and reads the resolved line level back through an input. A write sends the slave identifier, the sub-address and the value in one framed transfer. A read first sends the identifier and the sub-address as a framed transfer of its own. It then opens a second framed transfer with the identifier's low bit set and clocks one byte in from the slave. The ninth clock after each byte is always sent with the line released, and its level is never examined. Settle time, clock-high time and the idle guard are parameters counted in system clock cycles.

Top module: `sccb_master`

## Requirements
- R1: Out of reset, and in the done cycle, the clock output is 1, the pull-low enable `sda_oe` is 0 (line released), `busy` is 0 and `done` is 0 after reset.
- R2: A framing start keeps both lines high for SETTLE_CYC cycles. The data line then falls while the clock is high, and the clock falls SETTLE_CYC cycles after that fall.
- R3: A framing stop pulls the data line low while the clock is low, raises the clock SETTLE_CYC cycles later and releases the data line a further SETTLE_CYC cycles later.
- R4: Bytes go out most significant bit first. The data line changes only while the clock is low, and each clock-high pulse lasts HIGH_CYC cycles.
- R5: The ninth clock of every byte, written or read, is sent with the data line released, so it reads as 1. The slave's level there has no effect on the transfer.
- R6: A write request produces start, identifier 0x60, sub-address, data byte, stop.
- R7: A read request produces start, 0x60, sub-address, stop, then start, 0x61, one byte clocked in, stop. The line is sampled while the clock is high, the first bit received is the most significant bit of `rdata`, and `rdata` is valid in the done cycle.
- R8: During the eight data bits of the read byte the master keeps `sda_oe` at 0.
- R9: `done` is high for exactly one cycle. It rises SETTLE_CYC+GUARD_CYC cycles after the data line is released at the final stop.
- R10: `busy` is 1 from the cycle after a request is accepted until the done cycle. A request presented while `busy` is 1 is ignored and causes no bus activity.
- R11: A request presented in the done cycle is accepted, and its start begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 8 | Register sub-address |
| req_wdata | input | 8 | Value for a write |
| busy | output | 1 | Transfer or guard time in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rdata | output | 8 | Byte returned by the last read |
| scl | output | 1 | Bus clock line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Resolved data line level |

## Verification
The end of one transfer's guard time and the acceptance of the next request can fall in the same cycle. The bench holds `req_valid` high through a whole write, so the request is ignored for as long as `busy` is 1. When `done` appears, the bench switches the fields to a second write. The bench expects that request to be taken on the next edge, and the scoreboard checks that exactly one extra framed write follows with no stray start in between. A separate monitor measures settle, clock-high and guard times in cycles and decodes every byte off the wires.

// File: rtl/sccb_pkg.sv
package sccb_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STA0,
      ST_STA1,
      ST_STA2,
      ST_BSET,
      ST_BHI,
      ST_BLO,
      ST_STO0,
      ST_STO1,
      ST_STO2,
      ST_GUARD
   } sccb_st_e;

   // Byte on the wire for a given pass and slot of the transfer
   function automatic logic [7:0] pick_byte(
      input logic [7:0] id,
      input logic       ps,
      input logic [1:0] idx,
      input logic [7:0] addr,
      input logic [7:0] wdata);
      logic [7:0] b;
      case (idx)
         2'd0:    b = {id[7:1], ps};
         2'd1:    b = ps ? 8'hFF : addr;
         default: b = wdata;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/sccb_timer.sv
module sccb_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         expire
);

   logic [W-1:0] cnt;

   generate
      if (W < 1) begin : g_bad_w
         $error("sccb_timer: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= len;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign expire = (cnt == '0);

endmodule

// File: rtl/sccb_shift.sv
module sccb_shift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic         sin,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);

   generate
      if (W < 2) begin : g_bad_w
         $error("sccb_shift: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (load)   q <= din;
      else if (shift)  q <= {q[W-2:0], sin};
   end

endmodule

// File: rtl/sccb_master.sv
module sccb_master
   import sccb_pkg::*;
#(
   parameter int         SETTLE_CYC = 5000,
   parameter int         HIGH_CYC   = 5000,
   parameter int         GUARD_CYC  = 625000,
   parameter logic [7:0] SLAVE_ID   = 8'h60
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_valid,
   input  logic       req_read,
   input  logic [7:0] req_addr,
   input  logic [7:0] req_wdata,
   output logic       busy,
   output logic       done,
   output logic [7:0] rdata,
   output logic       scl,
   output logic       sda_oe,
   input  logic       sda_in
);

   localparam int MAX_SH  = (SETTLE_CYC > HIGH_CYC) ? SETTLE_CYC : HIGH_CYC;
   localparam int MAX_CYC = (MAX_SH > GUARD_CYC) ? MAX_SH : GUARD_CYC;
   localparam int TW      = $clog2(MAX_CYC + 1);
   localparam int BYTE_W  = 8;
   localparam logic [TW-1:0] LEN_SET   = TW'(SETTLE_CYC - 1);
   localparam logic [TW-1:0] LEN_HIGH  = TW'(HIGH_CYC - 1);
   localparam logic [TW-1:0] LEN_GUARD = TW'(GUARD_CYC - 1);
   localparam logic [3:0]    NINTH     = 4'd8;

   generate
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("sccb_master: SETTLE_CYC must be at least 1");
      end
      if (HIGH_CYC < 1) begin : g_bad_high
         $error("sccb_master: HIGH_CYC must be at least 1");
      end
      if (GUARD_CYC < 1) begin : g_bad_guard
         $error("sccb_master: GUARD_CYC must be at least 1");
      end
      if (SLAVE_ID[0] != 1'b0) begin : g_bad_id
         $error("sccb_master: SLAVE_ID must have bit 0 clear");
      end
   endgenerate

   sccb_st_e          st, st_nx;
   logic              is_rd, pass, samp, done_q;
   logic [7:0]        addr_q, wdata_q, rdata_q;
   logic [1:0]        byte_idx;
   logic [3:0]        bit_cnt;
   logic              t_load, t_exp;
   logic [TW-1:0]     t_len;
   logic              sh_load, sh_shift;
   logic [BYTE_W-1:0] sh_din, sh_q;
   logic              last_byte, rd_byte;

   assign last_byte = (byte_idx == (is_rd ? 2'd1 : 2'd2));
   assign rd_byte   = is_rd && pass && (byte_idx == 2'd1);

   sccb_timer #(.W(TW)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (t_load),
      .len    (t_len),
      .expire (t_exp)
   );

   sccb_shift #(.W(BYTE_W)) u_sh (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sh_load),
      .shift (sh_shift),
      .sin   (samp),
      .din   (sh_din),
      .q     (sh_q)
   );

   // next state
   always_comb begin
      st_nx = st;
      case (st)
         ST_IDLE:  if (req_valid) st_nx = ST_STA0;
         ST_STA0:  if (t_exp) st_nx = ST_STA1;
         ST_STA1:  if (t_exp) st_nx = ST_STA2;
         ST_STA2:  if (t_exp) st_nx = ST_BSET;
         ST_BSET:  if (t_exp) st_nx = ST_BHI;
         ST_BHI:   if (t_exp) st_nx = ST_BLO;
         ST_BLO:   if (t_exp) st_nx = (bit_cnt == NINTH && last_byte) ? ST_STO0 : ST_BSET;
         ST_STO0:  if (t_exp) st_nx = ST_STO1;
         ST_STO1:  if (t_exp) st_nx = ST_STO2;
         ST_STO2:  if (t_exp) st_nx = (is_rd && !pass) ? ST_STA0 : ST_GUARD;
         ST_GUARD: if (t_exp) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   // interval for the state being entered
   always_comb begin
      t_load = (st_nx != st);
      case (st_nx)
         ST_BHI:   t_len = LEN_HIGH;
         ST_GUARD: t_len = LEN_GUARD;
         ST_IDLE:  t_len = '0;
         default:  t_len = LEN_SET;
      endcase
   end

   // shifter control
   always_comb begin
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      sh_din   = '0;
      if (st == ST_STA2 && t_exp) begin
         sh_load = 1'b1;
         sh_din  = pick_byte(SLAVE_ID, pass, byte_idx, addr_q, wdata_q);
      end else if (st == ST_BLO && t_exp) begin
         if (bit_cnt == NINTH) begin
            if (!last_byte) begin
               sh_load = 1'b1;
               sh_din  = pick_byte(SLAVE_ID, pass, 2'(byte_idx + 2'd1), addr_q, wdata_q);
            end
         end else begin
            sh_shift = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         is_rd    <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         pass     <= 1'b0;
         byte_idx <= '0;
         bit_cnt  <= '0;
         samp     <= 1'b1;
         rdata_q  <= '0;
         done_q   <= 1'b0;
      end else begin
         st     <= st_nx;
         done_q <= 1'b0;
         case (st)
            ST_IDLE: if (req_valid) begin
               is_rd    <= req_read;
               addr_q   <= req_addr;
               wdata_q  <= req_wdata;
               pass     <= 1'b0;
               byte_idx <= '0;
               bit_cnt  <= '0;
            end
            ST_BHI: if (t_exp) samp <= sda_in;
            ST_BLO: if (t_exp) begin
               if (bit_cnt == NINTH) begin
                  bit_cnt <= '0;
                  if (!last_byte) byte_idx <= 2'(byte_idx + 2'd1);
               end else begin
                  bit_cnt <= 4'(bit_cnt + 4'd1);
               end
            end
            ST_STO2: if (t_exp && is_rd && !pass) begin
               pass     <= 1'b1;
               byte_idx <= '0;
            end
            ST_GUARD: if (t_exp) begin
               done_q <= 1'b1;
               if (is_rd) rdata_q <= sh_q;
            end
            default: ;
         endcase
      end
   end

   // line drive
   always_comb begin
      scl    = 1'b1;
      sda_oe = 1'b0;
      case (st)
         ST_STA1: sda_oe = 1'b1;
         ST_STA2: begin scl = 1'b0; sda_oe = 1'b1; end
         ST_BSET, ST_BHI, ST_BLO: begin
            scl    = (st == ST_BHI);
            sda_oe = (bit_cnt != NINTH) && !rd_byte && !sh_q[BYTE_W-1];
         end
         ST_STO0: begin scl = 1'b0; sda_oe = 1'b1; end
         ST_STO1: sda_oe = 1'b1;
         default: ;
      endcase
   end

   assign busy  = (st != ST_IDLE);
   assign done  = done_q;
   assign rdata = rdata_q;

   AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (scl && !sda_oe && !busy)) else $error("done with bus active"); // R1

   AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BHI && $past(st) == ST_BHI) |-> $stable(sda_oe)) else $error("data moved with clock high"); // R4

   AST_NINTH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (scl && st == ST_BHI && bit_cnt == NINTH) |-> !sda_oe) else $error("ninth bit pulled low"); // R5

   AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BHI && rd_byte) |-> !sda_oe) else $error("master drove during read byte"); // R8

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done longer than one cycle"); // R9

   AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> ($stable(addr_q) && $stable(is_rd) && $stable(wdata_q))) else $error("request taken while busy"); // R10

endmodule

// File: tb/sim_sccb_master.sv
module sim_sccb_master;

   localparam int SET = 3;
   localparam int HI  = 4;
   localparam int GRD = 20;
   localparam int EV_START = 256;
   localparam int EV_STOP  = 257;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic       req_read = 1'b0;
   logic [7:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic       busy, done, scl, sda_oe;
   logic [7:0] rdata;
   logic       slv_low = 1'b0;
   logic       sda_bus;

   assign sda_bus = !(sda_oe || slv_low);

   always #4 clk = ~clk;

   sccb_master #(
      .SETTLE_CYC (SET),
      .HIGH_CYC   (HI),
      .GUARD_CYC  (GRD),
      .SLAVE_ID   (8'h60)
   ) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_read  (req_read),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .busy      (busy),
      .done      (done),
      .rdata     (rdata),
      .scl       (scl),
      .sda_oe    (sda_oe),
      .sda_in    (sda_bus)
   );

   int nchk = 0;
   int nerr = 0;
   int expq[$];
   logic [7:0] slv_val = '0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic expect_write(input logic [7:0] a, input logic [7:0] d);
      expq.push_back(EV_START); expq.push_back(32'h60);
      expq.push_back(int'(a));  expq.push_back(int'(d));
      expq.push_back(EV_STOP);
   endtask

   task automatic expect_read(input logic [7:0] a, input logic [7:0] v);
      slv_val = v;
      expq.push_back(EV_START); expq.push_back(32'h60);
      expq.push_back(int'(a));  expq.push_back(EV_STOP);
      expq.push_back(EV_START); expq.push_back(32'h61);
      expq.push_back(int'(v));  expq.push_back(EV_STOP);
   endtask

   task automatic issue(input logic rd, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_read = rd; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
   endtask

   task automatic wait_done();
      while (done !== 1'b1) @(negedge clk);
      chk(busy == 1'b0, "R10 busy low in done cycle", int'(busy), 0);
   endtask

   // ---------------- monitor / scoreboard ----------------
   int  cyc = 0;
   bit  p_scl = 1, p_sda = 1, p_done = 0;
   int  nb = 0;
   logic [8:0] sh9 = '0;
   int  rise_cyc = 0, start_cyc = 0, stop_cyc = 0, hi_cnt = 0;
   bit  chk_start = 0, slv_arm = 0;
   int  slv_k = 0;

   task automatic pop_cmp(input int got, input string req);
      if (expq.size() == 0) begin
         chk(0, {req, " unexpected bus event"}, got, -1);
      end else begin
         int e;
         e = expq.pop_front();
         chk(got == e, req, got, e);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (scl && p_scl && p_sda && !sda_bus) begin
            pop_cmp(EV_START, "R2 start event");
            nb = 0; start_cyc = cyc; chk_start = 1;
         end
         if (scl && p_scl && !p_sda && sda_bus) begin
            pop_cmp(EV_STOP, "R3 stop event");
            chk(cyc - rise_cyc == SET, "R3 stop clock-to-data", cyc - rise_cyc, SET);
            stop_cyc = cyc;
         end
         if (!p_scl && scl) begin
            rise_cyc = cyc;
            hi_cnt = 1;
            sh9 = {sh9[7:0], sda_bus};
            nb++;
            if (nb == 9) begin
               chk(sh9[0] == 1'b1, "R5 ninth bit released", int'(sh9[0]), 1);
               pop_cmp(int'(sh9[8:1]), "R6/R7 byte");
               if (sh9[8:1] == 8'h61) begin slv_arm = 1; slv_k = 0; end
               nb = 0;
            end
         end else if (scl) begin
            hi_cnt++;
         end
         if (p_scl && !scl) begin
            if (chk_start) begin
               chk(cyc - start_cyc == SET, "R2 start data-to-clock", cyc - start_cyc, SET);
               chk_start = 0;
            end else begin
               chk(hi_cnt == HI, "R4 clock high time", hi_cnt, HI);
            end
            if (slv_arm) begin
               if (slv_k < 8) begin
                  slv_low = !slv_val[7 - slv_k];
                  slv_k++;
               end else begin
                  slv_low = 1'b0;
                  slv_arm = 0;
               end
            end
         end
         if (done) begin
            chk(cyc - stop_cyc == SET + GRD, "R9 guard time", cyc - stop_cyc, SET + GRD);
            chk(!p_done, "R9 done single cycle", int'(p_done), 0);
         end
         p_done = done;
      end
      p_scl = scl;
      p_sda = sda_bus;
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      chk(scl == 1'b1, "R1 reset scl", int'(scl), 1);
      chk(sda_oe == 1'b0, "R1 reset sda_oe", int'(sda_oe), 0);
      chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
      chk(done == 1'b0, "R1 reset done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R6 writes, two patterns
      expect_write(8'h12, 8'h80);
      issue(1'b0, 8'h12, 8'h80);
      wait_done();
      chk(scl && !sda_oe, "R1 lines released at done", {scl, sda_oe}, 2);
      expect_write(8'h3A, 8'h0D);
      issue(1'b0, 8'h3A, 8'h0D);
      wait_done();

      // R7 reads
      expect_read(8'h1C, 8'h7F);
      issue(1'b1, 8'h1C, 8'h00);
      wait_done();
      chk(rdata == 8'h7F, "R7 rdata", int'(rdata), 8'h7F);
      expect_read(8'h0B, 8'hA2);
      issue(1'b1, 8'h0B, 8'h00);
      wait_done();
      chk(rdata == 8'hA2, "R7 R8 rdata", int'(rdata), 8'hA2);

      // R10 requests while busy are ignored
      expect_write(8'h11, 8'h55);
      issue(1'b0, 8'h11, 8'h55);
      repeat (30) @(negedge clk);
      req_valid = 1'b1; req_read = 1'b1; req_addr = 8'hEE;
      repeat (40) @(negedge clk);
      req_valid = 1'b0;
      wait_done();
      repeat (12) @(negedge clk);
      chk(busy == 1'b0, "R10 no extra transfer", int'(busy), 0);
      chk(rdata == 8'hA2, "R10 rdata untouched", int'(rdata), 8'hA2);

      // R11 request in the done cycle, held valid throughout
      expect_write(8'h40, 8'hC1);
      expect_write(8'h29, 8'h3F);
      @(negedge clk);
      req_valid = 1'b1; req_read = 1'b0; req_addr = 8'h40; req_wdata = 8'hC1;
      @(negedge clk);
      while (done !== 1'b1) @(negedge clk);
      req_addr = 8'h29; req_wdata = 8'h3F;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy == 1'b1, "R11 accepted in done cycle", int'(busy), 1);
      wait_done();
      repeat (5) @(negedge clk);

      chk(expq.size() == 0, "R6 all expected events seen", expq.size(), 0);
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         chk(0, "watchdog expired", 0, 1);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

endmodule